// File: doc/BRIEF.md
# Two-Socket Card Controller Configuration Registers

This block is the configuration register space of a bus-attached controller that serves two card sockets. The host reaches it with single-cycle configuration reads and writes to 32-bit words, each write carrying four byte enables. The block holds a small part of the standard header: an I/O base register, the interrupt line and pin bytes, and several words that must read as zero. It also holds four byte-wide extension registers per socket and a shared pair of interrupt-drive registers. Its outputs are the decoded control fields that the rest of the controller uses, a one-cycle soft-reset pulse and a one-cycle write-buffer flush strobe per socket, and a sticky card-interrupt flag per socket.

Read data comes from a two-state response machine. In `RD_IDLE` no read data is valid. A read request moves it to `RD_RESP` (transition *accept*) and loads the addressed word. While requests keep coming it stays in `RD_RESP` (transition *chain*) and reloads the data each cycle. A cycle with no request returns it to `RD_IDLE` (transition *drain*). The address port carries the byte-address bits 7..2, so each access covers one aligned word.

Top module: `cfgrf_top`

## Requirements
- R1: After reset, word 10h reads 0000_0001h, word 3Ch reads 0000_0100h, words 40h and 44h read 0002_0100h when that socket's buffer reports empty and not full, and word 48h reads zero. Both speaker enables are 1. No pulse or strobe is active.
- R2: Word 10h holds bits 31..2 as read/write and drives them on `io_base`. Bit 1 always reads 0 and bit 0 always reads 1.
- R3: Words 14h, 18h, 1Ch, 20h, 24h, 28h, 2Ch, 30h, 34h and 38h always read zero, and writes to them are ignored.
- R4: In word 3Ch, bits 31..16 read 0 and bits 15..8 read 01h. Bits 7..0 are read/write and drive no output.
- R5: A write changes only the bytes whose enable is 1 (`cfg_be[i]` guards data bits 8i+7..8i). Other bytes keep their value.
- R6: Byte 0 of a socket word (40h for socket 0, 44h for socket 1) is the init register. Bits 5..4 are the clock code and bit 2 is the high index-range select. Writing 1 to bit 0 pulses `soft_rst` for exactly one cycle and leaves the bit reading 0. Bits 7..6, 3 and 1 read 0.
- R7: Byte 1 of a socket word is the write-buffer control register. Bit 4 selects I/O-and-memory buffering, bit 3 selects one-deep mode and bit 2 enables the buffer. Bit 1 reads `wbuf_full` and bit 0 reads `wbuf_empty`. Writing 1 to bit 0 pulses `wbuf_flush` for one cycle. Writing 0 to bit 0 has no effect.
- R8: Byte 2 of a socket word is the misc register. Bit 4 enables the disk special mode and bit 1 enables the speaker. Byte 3 is the memory page, driven on `mem_page`. Reserved bits read 0.
- R9: Bit 0 of byte 2 is a sticky flag. It sets in the cycle after `card_irq` is high, stays set after `card_irq` falls, clears when 1 is written to it, and is unchanged when 0 is written to it.
- R10: If `card_irq` is high in the same cycle as a write-1 clear, the flag stays set.
- R11: Word 48h holds drive-mode bits 3..0 in byte 0 and bits 5..0 in byte 1, driven on `irq_drive_lo` and `irq_drive_hi`. Its other bits read 0.
- R12: A read returns its data with `cfg_rvalid` high in the cycle after the request. `cfg_rvalid` is low in the cycle after a cycle with no request. A read and a write to the same word in the same cycle return the value from before the write.
- R13: The two sockets are independent: a write to one socket's word changes nothing in the other socket.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_rd | input | 1 | Read request this cycle |
| cfg_wr | input | 1 | Write request this cycle |
| cfg_addr | input | 6 | Byte address bits 7..2 (word select) |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rvalid | output | 1 | Read data valid |
| cfg_rdata | output | 32 | Read data |
| card_irq | input | 2 | Card interrupt request per socket |
| wbuf_full | input | 2 | Write-buffer full status per socket |
| wbuf_empty | input | 2 | Write-buffer empty status per socket |
| io_base | output | 32 | I/O base value, bit 0 set |
| clk_code | output | 4 | Clock-frequency code, 2 bits per socket |
| idx_high | output | 2 | High index-range select per socket |
| soft_rst | output | 2 | One-cycle soft-reset pulse per socket |
| wb_io | output | 2 | Buffer I/O writes too, per socket |
| wb_one_deep | output | 2 | One-deep buffer mode per socket |
| wb_en | output | 2 | Write buffer enable per socket |
| wbuf_flush | output | 2 | One-cycle flush strobe per socket |
| ata_en | output | 2 | Disk special-mode enable per socket |
| spk_en | output | 2 | Speaker routing enable per socket |
| irq_flag | output | 2 | Sticky card-interrupt flag per socket |
| mem_page | output | 16 | Memory window page, 8 bits per socket |
| irq_drive_lo | output | 4 | Drive mode for the first four interrupt outputs |
| irq_drive_hi | output | 6 | Drive mode for the other six interrupt outputs |

## Verification
Every result is due one cycle after its stimulus. Read data and `cfg_rvalid` come on the edge after the request. Control outputs, pulses and strobes come on the edge that takes the write, and the interrupt flag on the edge that samples `card_irq`. The bench changes inputs on the falling edge and samples at the next falling edge, which is one rising edge later. It samples pulses there and samples them again one cycle later to confirm that they have dropped. A read in the same cycle as a write is compared against the value from before the write.

// File: rtl/cfgrf_pkg.sv
package cfgrf_pkg;

    localparam int NSOCK    = 2;
    localparam int DW       = 32;
    localparam int BEW      = DW / 8;
    localparam int WAW      = 6;

    localparam logic [WAW-1:0] W_BAR0  = 6'h04;
    localparam logic [WAW-1:0] W_ILR   = 6'h0F;
    localparam logic [WAW-1:0] W_SOCK0 = 6'h10;
    localparam logic [WAW-1:0] W_IMODE = 6'h12;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_RESP = 1'b1
    } rd_state_t;

    typedef struct packed {
        logic [1:0] clk_code;
        logic       idx_high;
        logic       wb_io;
        logic       wb_one_deep;
        logic       wb_en;
        logic       ata_en;
        logic       spk_en;
        logic [7:0] page;
    } sock_ctl_t;

    function automatic logic [WAW-1:0] sock_word(input int s);
        return W_SOCK0 + s[WAW-1:0];
    endfunction

endpackage

// File: rtl/cfgrf_common.sv
module cfgrf_common
    import cfgrf_pkg::*;
#(
    parameter logic [7:0] PIN_CODE = 8'h01
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bar_we,
    input  logic          ilr_we,
    input  logic          imode_we,
    input  logic [BEW-1:0] be,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  bar_rd,
    output logic [DW-1:0]  ilr_rd,
    output logic [DW-1:0]  imode_rd,
    output logic [3:0]     irq_lo,
    output logic [5:0]     irq_hi
);

    logic [DW-1:2] bar_q;
    logic [7:0]    line_q;
    logic [3:0]    lo_q;
    logic [5:0]    hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bar_q <= '0;
        end else if (bar_we) begin
            for (int b = 0; b < BEW; b++) begin
                if (be[b]) begin
                    for (int i = 8*b; i < 8*b+8; i++) begin
                        if (i >= 2) bar_q[i] <= wdata[i];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
        end else if (ilr_we && be[0]) begin
            line_q <= wdata[7:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (imode_we) begin
            if (be[0]) lo_q <= wdata[3:0];
            if (be[1]) hi_q <= wdata[13:8];
        end
    end

    always_comb begin
        bar_rd   = {bar_q, 2'b01};
        ilr_rd   = {16'h0000, PIN_CODE, line_q};
        imode_rd = {18'h0, hi_q, 4'h0, lo_q};
        irq_lo   = lo_q;
        irq_hi   = hi_q;
    end

    // R2
    bar_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bar_we && be[3]) |=> (bar_rd[31:24] == $past(wdata[31:24])));

    // R5
    bar_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bar_we || !be[2]) |=> $stable(bar_rd[23:16]));

endmodule

// File: rtl/cfgrf_socket.sv
module cfgrf_socket
    import cfgrf_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_hit,
    input  logic [BEW-1:0] be,
    input  logic [DW-1:0]  wdata,
    input  logic           card_irq,
    input  logic           buf_full,
    input  logic           buf_empty,
    output logic [DW-1:0]  rd_word,
    output sock_ctl_t      ctl,
    output logic           irq_flag,
    output logic           soft_rst,
    output logic           flush
);

    logic       wr_init, wr_wbuf, wr_misc, wr_page;
    logic [1:0] code_q;
    logic       idx_q, io_q, deep_q, en_q, ata_q, spk_q, flag_q;
    logic [7:0] page_q;
    logic       srst_q, flush_q;
    logic       unused_wbits;

    assign wr_init = wr_hit && be[0];
    assign wr_wbuf = wr_hit && be[1];
    assign wr_misc = wr_hit && be[2];
    assign wr_page = wr_hit && be[3];

    assign unused_wbits = ^{wdata[1], wdata[3], wdata[7:6], wdata[9],
                            wdata[15:13], wdata[19:18], wdata[23:21]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= 2'b00;
            idx_q  <= 1'b0;
        end else if (wr_init) begin
            code_q <= wdata[5:4];
            idx_q  <= wdata[2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            io_q   <= 1'b0;
            deep_q <= 1'b0;
            en_q   <= 1'b0;
        end else if (wr_wbuf) begin
            io_q   <= wdata[12];
            deep_q <= wdata[11];
            en_q   <= wdata[10];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ata_q <= 1'b0;
            spk_q <= 1'b1;
        end else if (wr_misc) begin
            ata_q <= wdata[20];
            spk_q <= wdata[17];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (wr_page) begin
            page_q <= wdata[31:24];
        end
    end

    // sticky flag: a set in the same cycle as a clear wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (card_irq) begin
            flag_q <= 1'b1;
        end else if (wr_misc && wdata[16]) begin
            flag_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            srst_q  <= 1'b0;
            flush_q <= 1'b0;
        end else begin
            srst_q  <= wr_init && wdata[0];
            flush_q <= wr_wbuf && wdata[8];
        end
    end

    always_comb begin
        rd_word = {page_q,
                   3'b000, ata_q, 2'b00, spk_q, flag_q,
                   3'b000, io_q, deep_q, en_q, buf_full, buf_empty,
                   2'b00, code_q, 1'b0, idx_q, 2'b00};
        ctl.clk_code    = code_q;
        ctl.idx_high    = idx_q;
        ctl.wb_io       = io_q;
        ctl.wb_one_deep = deep_q;
        ctl.wb_en       = en_q;
        ctl.ata_en      = ata_q;
        ctl.spk_en      = spk_q;
        ctl.page        = page_q;
        irq_flag        = flag_q;
        soft_rst        = srst_q;
        flush           = flush_q;
    end

    // R9
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        card_irq |=> irq_flag);

    // R10
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && be[2] && wdata[16] && !card_irq) |=> !irq_flag);

    // R6
    srst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_hit && be[0] && wdata[0]) |=> !soft_rst);

    // R7
    flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_hit && be[1] && wdata[8]) |=> !flush);

    // R6
    init_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_word[7:6] == 2'b00) && (rd_word[3] == 1'b0) && (rd_word[1:0] == 2'b00));

endmodule

// File: rtl/cfgrf_rdfsm.sv
module cfgrf_rdfsm
    import cfgrf_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic [DW-1:0] rd_mux,
    output logic          rvalid,
    output logic [DW-1:0] rdata
);

    rd_state_t     st_q, st_nx;
    logic [DW-1:0] data_q;

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            RD_IDLE: if (rd_req)  st_nx = RD_RESP;
            RD_RESP: if (!rd_req) st_nx = RD_IDLE;
            default:              st_nx = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RD_IDLE;
        else        st_q <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      data_q <= '0;
        else if (rd_req) data_q <= rd_mux;
    end

    always_comb begin
        rvalid = (st_q == RD_RESP);
        rdata  = data_q;
    end

    // R12
    rvalid_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rvalid);

    // R12
    rvalid_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rvalid);

endmodule

// File: rtl/cfgrf_top.sv
module cfgrf_top
    import cfgrf_pkg::*;
#(
    parameter logic [7:0] PIN_CODE = 8'h01
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_rd,
    input  logic                 cfg_wr,
    input  logic [7:2]           cfg_addr,
    input  logic [BEW-1:0]       cfg_be,
    input  logic [DW-1:0]        cfg_wdata,
    output logic                 cfg_rvalid,
    output logic [DW-1:0]        cfg_rdata,
    input  logic [NSOCK-1:0]     card_irq,
    input  logic [NSOCK-1:0]     wbuf_full,
    input  logic [NSOCK-1:0]     wbuf_empty,
    output logic [DW-1:0]        io_base,
    output logic [2*NSOCK-1:0]   clk_code,
    output logic [NSOCK-1:0]     idx_high,
    output logic [NSOCK-1:0]     soft_rst,
    output logic [NSOCK-1:0]     wb_io,
    output logic [NSOCK-1:0]     wb_one_deep,
    output logic [NSOCK-1:0]     wb_en,
    output logic [NSOCK-1:0]     wbuf_flush,
    output logic [NSOCK-1:0]     ata_en,
    output logic [NSOCK-1:0]     spk_en,
    output logic [NSOCK-1:0]     irq_flag,
    output logic [8*NSOCK-1:0]   mem_page,
    output logic [3:0]           irq_drive_lo,
    output logic [5:0]           irq_drive_hi
);

    logic [WAW-1:0] word;
    logic [DW-1:0]  bar_rd, ilr_rd, imode_rd, rd_mux;
    logic [DW-1:0]  sock_rd  [NSOCK];
    sock_ctl_t      sock_ctl [NSOCK];

    assign word = cfg_addr;

    cfgrf_common #(.PIN_CODE(PIN_CODE)) u_common (
        .clk      (clk),
        .rst_n    (rst_n),
        .bar_we   (cfg_wr && (word == W_BAR0)),
        .ilr_we   (cfg_wr && (word == W_ILR)),
        .imode_we (cfg_wr && (word == W_IMODE)),
        .be       (cfg_be),
        .wdata    (cfg_wdata),
        .bar_rd   (bar_rd),
        .ilr_rd   (ilr_rd),
        .imode_rd (imode_rd),
        .irq_lo   (irq_drive_lo),
        .irq_hi   (irq_drive_hi)
    );

    for (genvar s = 0; s < NSOCK; s++) begin : g_sock
        cfgrf_socket u_sock (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_hit    (cfg_wr && (word == sock_word(s))),
            .be        (cfg_be),
            .wdata     (cfg_wdata),
            .card_irq  (card_irq[s]),
            .buf_full  (wbuf_full[s]),
            .buf_empty (wbuf_empty[s]),
            .rd_word   (sock_rd[s]),
            .ctl       (sock_ctl[s]),
            .irq_flag  (irq_flag[s]),
            .soft_rst  (soft_rst[s]),
            .flush     (wbuf_flush[s])
        );
        assign clk_code[2*s +: 2] = sock_ctl[s].clk_code;
        assign idx_high[s]        = sock_ctl[s].idx_high;
        assign wb_io[s]           = sock_ctl[s].wb_io;
        assign wb_one_deep[s]     = sock_ctl[s].wb_one_deep;
        assign wb_en[s]           = sock_ctl[s].wb_en;
        assign ata_en[s]          = sock_ctl[s].ata_en;
        assign spk_en[s]          = sock_ctl[s].spk_en;
        assign mem_page[8*s +: 8] = sock_ctl[s].page;
    end

    // unlisted words, reserved header words included, decode to zero
    always_comb begin
        rd_mux = '0;
        if (word == W_BAR0)  rd_mux = bar_rd;
        if (word == W_ILR)   rd_mux = ilr_rd;
        if (word == W_IMODE) rd_mux = imode_rd;
        for (int s = 0; s < NSOCK; s++) begin
            if (word == sock_word(s)) rd_mux = sock_rd[s];
        end
    end

    assign io_base = bar_rd;

    cfgrf_rdfsm u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_req (cfg_rd),
        .rd_mux (rd_mux),
        .rvalid (cfg_rvalid),
        .rdata  (cfg_rdata)
    );

    // R2
    bar_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && (cfg_addr == W_BAR0)) |=> (cfg_rdata[1:0] == 2'b01));

    // R3
    rom_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && (cfg_addr == 6'h0C)) |=> (cfg_rdata == '0));

    // R4
    ilr_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && (cfg_addr == W_ILR)) |=> (cfg_rdata[31:8] == {16'h0000, PIN_CODE}));

    // R11
    imode_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && (cfg_addr == W_IMODE)) |=> (cfg_rdata[31:14] == '0 && cfg_rdata[7:4] == 4'h0));

endmodule

// File: tb/tb_cfgrf_top.sv
`timescale 1ns/1ps
module tb_cfgrf_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_rd = 1'b0, cfg_wr = 1'b0;
    logic [7:2]  cfg_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_rvalid;
    logic [31:0] cfg_rdata;
    logic [1:0]  card_irq = 2'b00, wbuf_full = 2'b00, wbuf_empty = 2'b11;
    logic [31:0] io_base;
    logic [3:0]  clk_code;
    logic [1:0]  idx_high, soft_rst, wb_io, wb_one_deep, wb_en, wbuf_flush;
    logic [1:0]  ata_en, spk_en, irq_flag;
    logic [15:0] mem_page;
    logic [3:0]  irq_drive_lo;
    logic [5:0]  irq_drive_hi;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    cfgrf_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata),
        .card_irq(card_irq), .wbuf_full(wbuf_full), .wbuf_empty(wbuf_empty),
        .io_base(io_base), .clk_code(clk_code), .idx_high(idx_high),
        .soft_rst(soft_rst), .wb_io(wb_io), .wb_one_deep(wb_one_deep),
        .wb_en(wb_en), .wbuf_flush(wbuf_flush), .ata_en(ata_en),
        .spk_en(spk_en), .irq_flag(irq_flag), .mem_page(mem_page),
        .irq_drive_lo(irq_drive_lo), .irq_drive_hi(irq_drive_hi)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a[7:2]; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_rd = 1'b1; cfg_addr = a[7:2];
        @(negedge clk);
        cfg_rd = 1'b0;
        d = cfg_rdata;
        chk("R12 rvalid after read", {31'b0, cfg_rvalid}, 32'd1);
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    task automatic t_reset;
        chk("R1 spk_en reset", {30'b0, spk_en}, 32'd3);
        chk("R1 no pulse at reset", {28'b0, soft_rst, wbuf_flush}, 32'd0);
        rd_chk("R1 bar0 reset", 8'h10, 32'h0000_0001);
        rd_chk("R1 word 3C reset", 8'h3C, 32'h0000_0100);
        rd_chk("R1 socket0 reset", 8'h40, 32'h0002_0100);
        rd_chk("R1 socket1 reset", 8'h44, 32'h0002_0100);
        rd_chk("R1 imode reset", 8'h48, 32'h0);
    endtask

    task automatic t_bar;
        wr(8'h10, 4'hF, 32'hFFFF_FFFF);
        rd_chk("R2 bar0 all ones", 8'h10, 32'hFFFF_FFFD);
        chk("R2 io_base", io_base, 32'hFFFF_FFFD);
        wr(8'h10, 4'b0100, 32'h0000_0000);
        rd_chk("R5 bar0 byte2 only", 8'h10, 32'hFF00_FFFD);
        wr(8'h10, 4'b1000, 32'h1234_5678);
        rd_chk("R5 bar0 byte3 only", 8'h10, 32'h1200_FFFD);
    endtask

    task automatic t_reserved;
        wr(8'h14, 4'hF, 32'hFFFF_FFFF);
        wr(8'h28, 4'hF, 32'hFFFF_FFFF);
        wr(8'h30, 4'hF, 32'hFFFF_FFFF);
        wr(8'h38, 4'hF, 32'hFFFF_FFFF);
        rd_chk("R3 word 14 zero", 8'h14, 32'h0);
        rd_chk("R3 word 28 zero", 8'h28, 32'h0);
        rd_chk("R3 word 30 zero", 8'h30, 32'h0);
        rd_chk("R3 word 38 zero", 8'h38, 32'h0);
    endtask

    task automatic t_ilr;
        wr(8'h3C, 4'hF, 32'hFFFF_FFFF);
        rd_chk("R4 word 3C after ones", 8'h3C, 32'h0000_01FF);
        wr(8'h3C, 4'b0001, 32'h0000_005A);
        rd_chk("R4 line byte", 8'h3C, 32'h0000_015A);
    endtask

    task automatic t_init;
        wr(8'h40, 4'b0001, 32'h0000_00FF);
        chk("R6 soft_rst pulse", {30'b0, soft_rst}, 32'd1);
        @(negedge clk);
        chk("R6 soft_rst one cycle", {30'b0, soft_rst}, 32'd0);
        chk("R6 clk_code", {28'b0, clk_code}, 32'h3);
        chk("R6 idx_high", {30'b0, idx_high}, 32'd1);
        rd_chk("R6 init readback", 8'h40, 32'h0002_0134);
        rd_chk("R13 socket1 untouched", 8'h44, 32'h0002_0100);
    endtask

    task automatic t_wbuf;
        wr(8'h44, 4'b0010, 32'h0000_1F00);
        chk("R7 flush strobe", {30'b0, wbuf_flush}, 32'd2);
        @(negedge clk);
        chk("R7 flush one cycle", {30'b0, wbuf_flush}, 32'd0);
        chk("R7 buffer controls", {26'b0, wb_io, wb_one_deep, wb_en}, 32'h2A);
        rd_chk("R7 wbuf readback", 8'h44, 32'h0002_1D00);
        wr(8'h44, 4'b0010, 32'h0000_1C00);
        chk("R7 write 0 no flush", {30'b0, wbuf_flush}, 32'd0);
        wbuf_full = 2'b10; wbuf_empty = 2'b01;
        rd_chk("R7 status bits", 8'h44, 32'h0002_1E00);
        wbuf_full = 2'b00; wbuf_empty = 2'b11;
        rd_chk("R13 socket0 kept", 8'h40, 32'h0002_0134);
    endtask

    task automatic t_misc;
        wr(8'h40, 4'b1100, 32'hA5FE_0000);
        rd_chk("R8 misc and page", 8'h40, 32'hA512_0134);
        chk("R8 mem_page", {16'b0, mem_page}, 32'h0000_00A5);
        chk("R8 ata_en", {30'b0, ata_en}, 32'd1);
    endtask

    task automatic t_flag;
        @(negedge clk); card_irq = 2'b01;
        @(negedge clk); card_irq = 2'b00;
        chk("R9 flag set", {30'b0, irq_flag}, 32'd1);
        rd_chk("R9 flag sticky", 8'h40, 32'hA513_0134);
        wr(8'h40, 4'b0100, 32'h0012_0000);
        rd_chk("R9 write 0 keeps flag", 8'h40, 32'hA513_0134);
        wr(8'h40, 4'b0100, 32'h0013_0000);
        rd_chk("R9 write 1 clears", 8'h40, 32'hA512_0134);
    endtask

    task automatic t_setwins;
        @(negedge clk); card_irq = 2'b01;
        wr(8'h40, 4'b0100, 32'h0013_0000);
        card_irq = 2'b00;
        chk("R10 set wins", {30'b0, irq_flag}, 32'd1);
        wr(8'h40, 4'b0100, 32'h0013_0000);
        chk("R10 later clear", {30'b0, irq_flag}, 32'd0);
    endtask

    task automatic t_imode;
        wr(8'h48, 4'b0011, 32'h0000_FFFF);
        wr(8'h48, 4'b1100, 32'hFFFF_0000);
        rd_chk("R11 imode readback", 8'h48, 32'h0000_3F0F);
        chk("R11 drive outputs", {22'b0, irq_drive_hi, irq_drive_lo}, 32'h3FF);
    endtask

    task automatic t_rdwr;
        @(negedge clk);
        cfg_rd = 1'b1; cfg_wr = 1'b1; cfg_addr = 6'h0F; cfg_be = 4'b0001; cfg_wdata = 32'h77;
        @(negedge clk);
        cfg_rd = 1'b0; cfg_wr = 1'b0; cfg_be = '0;
        chk("R12 read before write", cfg_rdata, 32'h0000_015A);
        @(negedge clk);
        chk("R12 rvalid drops", {31'b0, cfg_rvalid}, 32'd0);
        rd_chk("R12 write landed", 8'h3C, 32'h0000_0177);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_bar;
        t_reserved;
        t_ilr;
        t_init;
        t_wbuf;
        t_misc;
        t_flag;
        t_setwins;
        t_imode;
        t_rdwr;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule